// File: doc/BRIEF.md
# Multi-Channel Byte DMA Controller

This block moves single bytes between a 12-bit-addressed RAM and four peripheral data ports on behalf of up to eight independent channels (seven by default). Software programs it through a small byte-wide register file. Each channel's configuration, base address, byte offset and transfer length sit in a bank. A channel-select register decides which bank the shared window reaches. Global registers hold one bit per channel for enable, busy, full-length flag and mid-point flag.

An enabled channel watches the request line of the port its function code names. When the request arrives, a fixed-priority arbiter may pick that channel. The port then gets an acknowledge, and on the next cycle the controller performs one RAM access at base plus offset, either reading a byte out to the port or writing the port's byte into RAM. The offset is the byte counter. When it reaches half the length, and again when it reaches the full length, the channel raises flags that can drive two interrupt lines. On reaching the full length the channel also disables itself. A per-channel stall bit holds back new transfers without cancelling the one already granted.

Top module: `chdma_top`

## Requirements
- R1: After reset, every global register and every channel register reads 0, both interrupt outputs are low and no memory access or acknowledge occurs.
- R2: Register map on `reg_addr`: 0 channel select (3 bits), 1 enable vector, 2 busy vector (read-only), 3 full flags, 4 mid flags, 8 config, 9/10 base high/low, 11/12 offset high/low, 13/14 length high/low. Offsets 8 to 14 reach only the channel named by the select register. High bytes keep only the implemented bits (4 for base, 2 for offset and length).
- R3: Config bits [2:1] name the peripheral port and bit 0 the direction (0: RAM read delivered on `pout_data` with `pout_valid` one-hot for that port; 1: the port's `pin_data` byte written to RAM). An acknowledge goes only to a requesting port.
- R4: The RAM address is base plus offset, taken modulo 4096. The offset rises by one after every byte.
- R5: With config bit 3 set, the byte at offset k uses address base + (k XOR 1).
- R6: At most one acknowledge per cycle. Among eligible channels the lowest-numbered wins, and a channel has at most one transfer outstanding.
- R7: While config bit 5 (stall) is set, a channel is granted nothing. A transfer granted in the same cycle that the stall is written still performs its memory access.
- R8: A channel's busy bit is 1 exactly in the cycle of its memory access.
- R9: When the offset after a byte equals floor(length/2), the channel's mid flag is set. When it equals the length, the full flag is set and the channel's enable bit clears.
- R10: Writing 1 to a bit of register 3 or 4 clears that flag. `irq_full` is the OR of full flags whose config bit 4 is set, and `irq_mid` the OR of mid flags whose config bit 6 is set.
- R11: A channel whose offset is not below its length, or whose enable bit is clear, makes no transfer even while its port requests.
- R12: An acknowledge in one cycle is followed by the memory access in the next cycle, and a memory access occurs only after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| prq | input | 4 | Per-port transfer request |
| pack | output | 4 | Per-port acknowledge, one-hot or zero |
| pin_data | input | 32 | Byte from each port toward RAM, port p in bits [8p+7:8p] |
| pout_valid | output | 4 | Per-port strobe for a byte read from RAM |
| pout_data | output | 8 | Byte read from RAM toward a port |
| mem_en | output | 1 | RAM access this cycle |
| mem_we | output | 1 | RAM access is a write |
| mem_addr | output | 12 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, same cycle |
| irq_full | output | 1 | Full-length interrupt |
| irq_mid | output | 1 | Mid-point interrupt |

## Verification
The hardest case to reach from the ports is a stall written in exactly the cycle in which the same channel is being acknowledged. The granted byte must still reach memory while every later byte is held back. The bench gets there by counting acknowledges at a fixed point in each cycle and, on the third one, driving the stall write before the next clock edge. It then reads the busy register and watches the memory strobe during the following cycle. Priority and the one-outstanding rule are reached by starting two channels with a single enable write, so that their transfers must interleave in a known order.

// File: rtl/chdma_pkg.sv
package chdma_pkg;

   localparam int BYTE_W = 8;
   localparam int SEL_W  = 3;
   localparam int PORTS  = 4;

   typedef enum logic [3:0] {
      RA_CHSEL  = 4'h0,
      RA_ENABLE = 4'h1,
      RA_BUSY   = 4'h2,
      RA_FULL   = 4'h3,
      RA_MID    = 4'h4,
      RA_CFG    = 4'h8,
      RA_BASE_H = 4'h9,
      RA_BASE_L = 4'hA,
      RA_OFS_H  = 4'hB,
      RA_OFS_L  = 4'hC,
      RA_LEN_H  = 4'hD,
      RA_LEN_L  = 4'hE
   } reg_addr_e;

   // channel configuration byte, bits 6..0
   typedef struct packed {
      logic       mid_ie;   // 6
      logic       stall;    // 5
      logic       full_ie;  // 4
      logic       big;      // 3
      logic [1:0] port;     // 2:1
      logic       to_ram;   // 0
   } chan_cfg_t;

endpackage

// File: rtl/chdma_prio.sv
module chdma_prio #(
   parameter int N = 7
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   logic [N:0] taken;
   assign taken[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_stage
      assign gnt[i]       = req[i] & ~taken[i];
      assign taken[i + 1] = taken[i] | req[i];
   end

endmodule

// File: rtl/chdma_chan.sv
module chdma_chan
   import chdma_pkg::*;
#(
   parameter int AW  = 12,
   parameter int OW  = 10,
   parameter int IDX = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   input  logic              done,
   output chan_cfg_t         cfg,
   output logic [AW-1:0]     base,
   output logic [OW-1:0]     ofs,
   output logic [OW-1:0]     len,
   output logic              en,
   output logic              full_f,
   output logic              mid_f
);

   logic [OW-1:0] nxt_ofs;
   logic          wr_bank;
   logic          hit_end;
   logic          hit_half;

   assign nxt_ofs  = ofs + OW'(1);
   assign wr_bank  = reg_we && sel;
   assign hit_end  = done && (nxt_ofs == len);
   assign hit_half = done && (nxt_ofs == (len >> 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg    <= '0;
         base   <= '0;
         ofs    <= '0;
         len    <= '0;
         en     <= 1'b0;
         full_f <= 1'b0;
         mid_f  <= 1'b0;
      end else begin
         if (wr_bank && reg_addr == RA_CFG)    cfg           <= chan_cfg_t'(reg_wdata[6:0]);
         if (wr_bank && reg_addr == RA_BASE_H) base[AW-1:8]  <= reg_wdata[AW-9:0];
         if (wr_bank && reg_addr == RA_BASE_L) base[7:0]     <= reg_wdata;
         if (wr_bank && reg_addr == RA_LEN_H)  len[OW-1:8]   <= reg_wdata[OW-9:0];
         if (wr_bank && reg_addr == RA_LEN_L)  len[7:0]      <= reg_wdata;

         if (wr_bank && reg_addr == RA_OFS_H)      ofs[OW-1:8] <= reg_wdata[OW-9:0];
         else if (wr_bank && reg_addr == RA_OFS_L) ofs[7:0]    <= reg_wdata;
         else if (done)                            ofs         <= nxt_ofs;

         if (reg_we && reg_addr == RA_ENABLE) en <= reg_wdata[IDX];
         else if (hit_end)                    en <= 1'b0;

         if (hit_end)                                            full_f <= 1'b1;
         else if (reg_we && reg_addr == RA_FULL && reg_wdata[IDX]) full_f <= 1'b0;

         if (hit_half)                                          mid_f <= 1'b1;
         else if (reg_we && reg_addr == RA_MID && reg_wdata[IDX]) mid_f <= 1'b0;
      end
   end

endmodule

// File: rtl/chdma_top.sv
module chdma_top
   import chdma_pkg::*;
#(
   parameter  int NCH   = 7,
   parameter  int AW    = 12,
   parameter  int OW    = 10,
   localparam int NPORT = PORTS,
   localparam int DW    = BYTE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [3:0]          reg_addr,
   input  logic [DW-1:0]       reg_wdata,
   output logic [DW-1:0]       reg_rdata,
   input  logic [NPORT-1:0]    prq,
   output logic [NPORT-1:0]    pack,
   input  logic [NPORT*DW-1:0] pin_data,
   output logic [NPORT-1:0]    pout_valid,
   output logic [DW-1:0]       pout_data,
   output logic                mem_en,
   output logic                mem_we,
   output logic [AW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata,
   input  logic [DW-1:0]       mem_rdata,
   output logic                irq_full,
   output logic                irq_mid
);

   if (NCH < 1 || NCH > (1 << SEL_W)) begin : g_bad_nch
      $error("chdma_top: NCH must lie in 1..8");
   end
   if (AW <= DW || AW > 2 * DW) begin : g_bad_aw
      $error("chdma_top: AW must lie in 9..16");
   end
   if (OW <= DW || OW > AW) begin : g_bad_ow
      $error("chdma_top: OW must lie in 9..AW");
   end

   logic [SEL_W-1:0] chsel_q;

   chan_cfg_t     cfg_a  [NCH];
   logic [AW-1:0] base_a [NCH];
   logic [OW-1:0] ofs_a  [NCH];
   logic [OW-1:0] len_a  [NCH];

   logic [NCH-1:0] en_v, full_v, mid_v, busy_v, want, gnt, stall_vec, fie_v, mie_v;

   // memory stage
   logic             st_v;
   logic [SEL_W-1:0] st_ch;
   logic             st_we;
   logic [1:0]       st_port;
   logic [AW-1:0]    st_addr;
   logic [DW-1:0]    st_data;

   // winner of this cycle
   logic             w_any;
   logic [SEL_W-1:0] w_ch;
   logic             w_we;
   logic [1:0]       w_port;
   logic [AW-1:0]    w_addr;
   logic [DW-1:0]    w_data;

   always_ff @(posedge clk) begin
      if (!rst_n)                               chsel_q <= '0;
      else if (reg_we && reg_addr == RA_CHSEL)  chsel_q <= reg_wdata[SEL_W-1:0];
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign busy_v[c] = st_v && (st_ch == SEL_W'(c));

      chdma_chan #(.AW(AW), .OW(OW), .IDX(c)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel       (chsel_q == SEL_W'(c)),
         .reg_we    (reg_we),
         .reg_addr  (reg_addr),
         .reg_wdata (reg_wdata),
         .done      (busy_v[c]),
         .cfg       (cfg_a[c]),
         .base      (base_a[c]),
         .ofs       (ofs_a[c]),
         .len       (len_a[c]),
         .en        (en_v[c]),
         .full_f    (full_v[c]),
         .mid_f     (mid_v[c])
      );

      assign stall_vec[c] = cfg_a[c].stall;
      assign fie_v[c]     = cfg_a[c].full_ie;
      assign mie_v[c]     = cfg_a[c].mid_ie;
      assign want[c]      = en_v[c] && !cfg_a[c].stall && (ofs_a[c] < len_a[c])
                            && !busy_v[c] && prq[cfg_a[c].port];
   end

   chdma_prio #(.N(NCH)) u_prio (
      .req (want),
      .gnt (gnt)
   );

   always_comb begin
      w_ch   = '0;
      w_we   = 1'b0;
      w_port = '0;
      w_addr = '0;
      for (int c = 0; c < NCH; c++) begin
         if (gnt[c]) begin
            w_ch   = SEL_W'(c);
            w_we   = cfg_a[c].to_ram;
            w_port = cfg_a[c].port;
            w_addr = base_a[c] + AW'(cfg_a[c].big ? (ofs_a[c] ^ OW'(1)) : ofs_a[c]);
         end
      end
   end

   assign w_any  = |gnt;
   assign w_data = pin_data[w_port*DW +: DW];

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign pack[p]       = w_any && (w_port == 2'(p));
      assign pout_valid[p] = st_v && !st_we && (st_port == 2'(p));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_v    <= 1'b0;
         st_ch   <= '0;
         st_we   <= 1'b0;
         st_port <= '0;
         st_addr <= '0;
         st_data <= '0;
      end else begin
         st_v <= w_any;
         if (w_any) begin
            st_ch   <= w_ch;
            st_we   <= w_we;
            st_port <= w_port;
            st_addr <= w_addr;
            st_data <= w_data;
         end
      end
   end

   assign mem_en    = st_v;
   assign mem_we    = st_v && st_we;
   assign mem_addr  = st_addr;
   assign mem_wdata = st_data;
   assign pout_data = mem_rdata;

   assign irq_full = |(full_v & fie_v);
   assign irq_mid  = |(mid_v & mie_v);

   // register read window
   chan_cfg_t     cur_cfg;
   logic [AW-1:0] cur_base;
   logic [OW-1:0] cur_ofs, cur_len;

   always_comb begin
      cur_cfg  = '0;
      cur_base = '0;
      cur_ofs  = '0;
      cur_len  = '0;
      for (int c = 0; c < NCH; c++) begin
         if (chsel_q == SEL_W'(c)) begin
            cur_cfg  = cfg_a[c];
            cur_base = base_a[c];
            cur_ofs  = ofs_a[c];
            cur_len  = len_a[c];
         end
      end
   end

   always_comb begin
      case (reg_addr)
         RA_CHSEL:  reg_rdata = DW'(chsel_q);
         RA_ENABLE: reg_rdata = DW'(en_v);
         RA_BUSY:   reg_rdata = DW'(busy_v);
         RA_FULL:   reg_rdata = DW'(full_v);
         RA_MID:    reg_rdata = DW'(mid_v);
         RA_CFG:    reg_rdata = {1'b0, cur_cfg};
         RA_BASE_H: reg_rdata = DW'(cur_base[AW-1:8]);
         RA_BASE_L: reg_rdata = cur_base[7:0];
         RA_OFS_H:  reg_rdata = DW'(cur_ofs[OW-1:8]);
         RA_OFS_L:  reg_rdata = cur_ofs[7:0];
         RA_LEN_H:  reg_rdata = DW'(cur_len[OW-1:8]);
         RA_LEN_L:  reg_rdata = cur_len[7:0];
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/chdma_chk.sv
module chdma_chk #(
   parameter int NCH   = 7,
   parameter int NPORT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPORT-1:0] pack,
   input logic             mem_en,
   input logic             mem_we,
   input logic [NPORT-1:0] pout_valid,
   input logic [NCH-1:0]   gnt,
   input logic [NCH-1:0]   stall_vec,
   input logic             irq_mid,
   input logic [NCH-1:0]   mid_v
);

   // R6
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pack));

   // R12
   ack_then_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|pack) |=> mem_en);

   // R12
   mem_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> $past(|pack));

   // R3
   read_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|pout_valid) |-> (mem_en && !mem_we));

   // R7
   stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & stall_vec) == '0);

   // R10
   mid_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mid |-> (|mid_v));

endmodule

bind chdma_top chdma_chk #(.NCH(NCH), .NPORT(NPORT)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pack       (pack),
   .mem_en     (mem_en),
   .mem_we     (mem_we),
   .pout_valid (pout_valid),
   .gnt        (gnt),
   .stall_vec  (stall_vec),
   .irq_mid    (irq_mid),
   .mid_v      (mid_v)
);

// File: tb/test_chdma_top.sv
module test_chdma_top;

   localparam int CLK_PERIOD = 10;

   localparam logic [3:0] A_SEL = 4'h0, A_EN = 4'h1, A_BUSY = 4'h2, A_FULL = 4'h3, A_MID = 4'h4;
   localparam logic [3:0] A_CFG = 4'h8, A_BH = 4'h9, A_BL = 4'hA, A_OH = 4'hB, A_OL = 4'hC;
   localparam logic [3:0] A_LH = 4'hD, A_LL = 4'hE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   wire  [7:0]  reg_rdata;
   logic [3:0]  prq = '0;
   wire  [3:0]  pack;
   logic [31:0] pin_data = '0;
   wire  [3:0]  pout_valid;
   wire  [7:0]  pout_data;
   wire         mem_en, mem_we;
   wire  [11:0] mem_addr;
   wire  [7:0]  mem_wdata;
   wire  [7:0]  mem_rdata;
   wire         irq_full, irq_mid;

   logic [7:0] ram [4096];
   assign mem_rdata = ram[mem_addr];

   always #(CLK_PERIOD / 2) clk = ~clk;

   chdma_top i_chdma_top (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .prq(prq), .pack(pack), .pin_data(pin_data),
      .pout_valid(pout_valid), .pout_data(pout_data), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .irq_full(irq_full), .irq_mid(irq_mid)
   );

   int nchk = 0;
   int nfail = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // scoreboard
   typedef struct {
      bit    we;
      int    port;
      int    addr;
      int    data;
      string req;
   } item_t;
   item_t exp_q[$];

   task automatic push_rd(input int port, input int base, input int ofs0, input int n,
                          input bit big, input string req);
      for (int k = 0; k < n; k++) begin
         int o;
         int a;
         o = ofs0 + k;
         if (big) o = o ^ 1;
         a = (base + o) & 12'hFFF;
         exp_q.push_back('{1'b0, port, a, int'(ram[a]), req});
      end
   endtask

   task automatic push_wr(input int port, input int base, input int ofs0, input int n,
                          input bit big, input int seq0, input string req);
      for (int k = 0; k < n; k++) begin
         int o;
         o = ofs0 + k;
         if (big) o = o ^ 1;
         exp_q.push_back('{1'b1, port, (base + o) & 12'hFFF, (seq0 + k) & 8'hFF, req});
      end
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mem_en) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7/R11", "unexpected memory access addr", mem_addr, 0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               check(mem_addr == it.addr[11:0], it.req, "mem_addr", mem_addr, it.addr);
               check(mem_we == it.we, it.req, "mem_we", mem_we, it.we);
               if (it.we)
                  check(mem_wdata == it.data[7:0], it.req, "mem_wdata", mem_wdata, it.data);
               else begin
                  check(pout_valid == 4'(1 << it.port), "R3", "pout_valid", pout_valid, 1 << it.port);
                  check(pout_data == it.data[7:0], it.req, "pout_data", pout_data, it.data);
               end
            end
            if (mem_we) ram[mem_addr] = mem_wdata;
         end
      end
   end

   // peripheral model
   int pend [4];
   int pseq [4];
   logic [3:0] ack_seen = '0;

   initial begin
      for (int p = 0; p < 4; p++) begin
         pend[p] = 0;
         pseq[p] = 0;
      end
      forever begin
         @(negedge clk);
         for (int p = 0; p < 4; p++) begin
            if (ack_seen[p]) begin
               pend[p]--;
               pseq[p]++;
            end
            prq[p] = pend[p] > 0;
            pin_data[p*8 +: 8] = 8'(pseq[p]);
         end
         #1;
         ack_seen = pack;
         if (pack != 0)
            check(((pack & ~prq) == 0) && $onehot(pack), "R3", "ack to requesting port", pack, prq);
      end
   end

   task automatic feed(input int p, input int n, input int seq0);
      @(posedge clk);
      #1;
      pend[p] = n;
      pseq[p] = seq0;
   endtask

   task automatic wr(input logic [3:0] a, input int d);
      @(negedge clk);
      #2;
      reg_we = 1'b1;
      reg_addr = a;
      reg_wdata = 8'(d);
      @(posedge clk);
      #1;
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input int exp, input string req, input string what);
      @(negedge clk);
      #2;
      reg_addr = a;
      #1;
      check(reg_rdata == 8'(exp), req, what, reg_rdata, exp);
   endtask

   task automatic setup(input int ch, input int cfg, input int base, input int ofs, input int len);
      wr(A_SEL, ch);
      wr(A_CFG, cfg);
      wr(A_BH, base >> 8);
      wr(A_BL, base & 8'hFF);
      wr(A_OH, ofs >> 8);
      wr(A_OL, ofs & 8'hFF);
      wr(A_LH, len >> 8);
      wr(A_LL, len & 8'hFF);
   endtask

   task automatic drain(input string req);
      int t;
      t = 0;
      while (exp_q.size() != 0 && t < 300) begin
         @(negedge clk);
         t++;
      end
      check(exp_q.size() == 0, req, "scoreboard drained, items left", exp_q.size(), 0);
      exp_q.delete();
      repeat (3) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4096; i++) ram[i] = 8'(i * 13 + 7);
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 15; a++) rd_chk(4'(a), 0, "R1", "register after reset");
      check(!irq_full && !irq_mid, "R1", "irq after reset", {irq_full, irq_mid}, 0);
      check(!mem_en && pack == 0, "R1", "idle bus after reset", {mem_en, pack}, 0);

      // R2 banking
      wr(A_SEL, 3);
      wr(A_BL, 8'h5A);
      wr(A_BH, 8'hFF);
      wr(A_SEL, 0);
      wr(A_BL, 8'h11);
      rd_chk(A_SEL, 0, "R2", "select readback");
      rd_chk(A_BL, 8'h11, "R2", "ch0 base low");
      wr(A_SEL, 3);
      rd_chk(A_BL, 8'h5A, "R2", "ch3 base low kept");
      rd_chk(A_BH, 8'h0F, "R2", "ch3 base high trimmed to 4 bits");

      // R4 R9 R10: ch0 reads to port 0, full irq enabled, mid irq disabled
      setup(0, 8'h10, 12'h100, 0, 6);
      feed(0, 6, 0);
      push_rd(0, 12'h100, 0, 6, 0, "R4");
      wr(A_EN, 8'h01);
      drain("R4");
      rd_chk(A_FULL, 8'h01, "R9", "full flag ch0");
      rd_chk(A_MID, 8'h01, "R9", "mid flag ch0");
      rd_chk(A_EN, 8'h00, "R9", "enable self-cleared");
      rd_chk(A_OL, 6, "R4", "offset counted to length");
      check(irq_full == 1'b1, "R10", "irq_full gated on", irq_full, 1);
      check(irq_mid == 1'b0, "R10", "irq_mid gated off", irq_mid, 0);
      wr(A_FULL, 8'h01);
      rd_chk(A_FULL, 0, "R10", "full flag cleared");
      check(irq_full == 1'b0, "R10", "irq_full after clear", irq_full, 0);
      wr(A_MID, 8'h7F);

      // R4 wrap: ch2 writes from port 1
      setup(2, 8'h03, 12'hFFE, 0, 4);
      feed(1, 4, 8'h90);
      push_wr(1, 12'hFFE, 0, 4, 0, 8'h90, "R4");
      wr(A_EN, 8'h04);
      drain("R4");
      check(ram[12'h001] == 8'h93, "R4", "wrapped byte in RAM", ram[12'h001], 8'h93);
      wr(A_FULL, 8'h7F);
      wr(A_MID, 8'h7F);

      // R5 big-endian: ch5 writes from port 2, mid irq enabled
      setup(5, 8'h4D, 12'h200, 0, 4);
      feed(2, 4, 8'h50);
      push_wr(2, 12'h200, 0, 4, 1, 8'h50, "R5");
      wr(A_EN, 8'h20);
      drain("R5");
      check(ram[12'h201] == 8'h50, "R5", "first byte swapped", ram[12'h201], 8'h50);
      check(irq_mid == 1'b1, "R10", "irq_mid gated on", irq_mid, 1);
      wr(A_MID, 8'h20);
      check(irq_mid == 1'b0, "R10", "irq_mid after clear", irq_mid, 0);
      wr(A_FULL, 8'h7F);

      // R6 priority and interleave: ch1 on port 0, ch4 on port 1
      setup(1, 8'h00, 12'h300, 0, 3);
      setup(4, 8'h02, 12'h400, 0, 3);
      feed(0, 3, 0);
      feed(1, 3, 0);
      for (int k = 0; k < 3; k++) begin
         push_rd(0, 12'h300, k, 1, 0, "R6");
         push_rd(1, 12'h400, k, 1, 0, "R6");
      end
      wr(A_EN, 8'h12);
      drain("R6");
      wr(A_FULL, 8'h7F);
      wr(A_MID, 8'h7F);

      // R9 nonzero start offset: half never reached
      setup(3, 8'h40, 12'h500, 2, 4);
      feed(0, 2, 0);
      push_rd(0, 12'h500, 2, 2, 0, "R9");
      wr(A_EN, 8'h08);
      drain("R9");
      rd_chk(A_MID, 0, "R9", "mid not set from offset 2");
      rd_chk(A_FULL, 8'h08, "R9", "full flag ch3");
      check(irq_mid == 1'b0, "R10", "irq_mid without flag", irq_mid, 0);

      // R11 offset equal to length: no transfer
      feed(0, 2, 0);
      wr(A_EN, 8'h08);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         #2;
         check(pack == 0, "R11", "no ack at offset==length", pack, 0);
      end
      wr(A_SEL, 3);
      rd_chk(A_OL, 4, "R11", "offset untouched");
      wr(A_EN, 0);
      feed(0, 0, 0);
      wr(A_FULL, 8'h7F);

      // R7 R8 stall: ch6 reads to port 3
      setup(6, 8'h26, 12'h600, 0, 8);
      feed(3, 8, 0);
      wr(A_EN, 8'h40);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         #2;
         check(pack == 0, "R7", "no ack while stalled", pack, 0);
      end
      rd_chk(A_OL, 0, "R7", "offset frozen under stall");
      push_rd(3, 12'h600, 0, 3, 0, "R7");
      wr(A_CFG, 8'h06);
      begin
         int acks;
         int t;
         acks = 0;
         t = 0;
         while (acks < 3 && t < 100) begin
            @(negedge clk);
            #2;
            t++;
            if (pack[3]) begin
               acks++;
               if (acks == 3) begin
                  reg_we = 1'b1;
                  reg_addr = A_CFG;
                  reg_wdata = 8'h26;
               end
            end
         end
         check(acks == 3, "R7", "acks before stall", acks, 3);
      end
      @(posedge clk);
      #1;
      reg_we = 1'b0;
      reg_addr = A_BUSY;
      #1;
      check(reg_rdata == 8'h40, "R8", "busy during in-flight byte", reg_rdata, 8'h40);
      check(mem_en == 1'b1, "R7", "in-flight byte completes", mem_en, 1);
      repeat (10) @(negedge clk);
      rd_chk(A_OL, 3, "R7", "offset after stall");
      rd_chk(A_BUSY, 0, "R8", "busy clear when idle");
      check(exp_q.size() == 0, "R7", "in-flight item consumed", exp_q.size(), 0);
      push_rd(3, 12'h600, 3, 5, 0, "R7");
      wr(A_CFG, 8'h06);
      drain("R7");
      rd_chk(A_FULL, 8'h40, "R9", "full flag ch6");
      rd_chk(A_EN, 0, "R9", "ch6 enable cleared");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule